// File: doc/BRIEF.md
# Two-Address Video Control Register Bank

This block sits between a CPU bus and a character-based video timing generator. It exposes the timing generator's whole set of control registers through only two bus addresses. A write to address 0 chooses which internal register later accesses reach. A read of address 0 returns a status byte. An access to address 1 goes to the internal register that was chosen last. To set register 6 to 13, the CPU writes 6 to address 0 and then 13 to address 1.

The bank keeps these values: line and frame totals, displayed widths and heights, sync positions and widths, scanlines per character row, and the cursor shape. It also holds the 14-bit display start address and the 14-bit cursor address, and drives all of them to the timing generator as decoded fields. A light-pen strobe captures the current 14-bit memory address into two read-only registers and raises a status flag. An update strobe raises a second flag. Each flag clears as a side effect of a CPU access to particular register numbers. A third status bit shows, live, whether the scan is in vertical retrace.

Bus accesses are synchronous. An access is qualified by `bus_cs` and takes effect on the rising clock edge. `bus_rdata` is a combinational view of the addressed location while the access is presented.

Top module: `vidctl_regbank`

## Requirements
- R1: A write to address 0 loads the register index from bits 4:0 of the write data and ignores bits 7:5. The index stays until the next such write. Reset sets the index to 0.
- R2: Reading address 0 returns the status byte: bit 7 update-ready, bit 6 pen-full, bit 5 equal to the live `vretrace` input, bits 4:0 zero. Reset clears both flags, and all control registers reset to 0.
- R3: A write to address 1 stores the data into the selected register, keeping only its implemented bits. A read of address 1 returns the stored value. Implemented bits per index are: 0–3 all 8 bits; 4, 6 and 7 bits 6:0; 5, 9 and 11 bits 4:0; 10 bits 6:0; 12 and 14 bits 5:0; 13 and 15 all 8 bits.
- R4: Indices 8 and 18–31 read as 0, and writes to them are ignored. Indices 16 and 17 are read-only, and writes to them leave their contents unchanged.
- R5: On a clock edge with `pen_strobe` high, bits 13:8 of `scan_addr` are captured into index 16, in bits 5:0. Bits 7:0 are captured into index 17. Pen-full is set on the same edge.
- R6: A read of index 16 or 17 clears pen-full on that edge. If `pen_strobe` is high on the same edge, pen-full stays set and the new address is captured.
- R7: `update_strobe` sets update-ready. A read or a write of index 31 clears it. A strobe on the same edge as that access wins.
- R8: The field outputs follow the registers from the edge of the write. The fields are:
  - `start_addr` = {idx12[5:0], idx13} and `cursor_addr` = {idx14[5:0], idx15}.
  - `hsync_width` = idx3[3:0] and `vsync_width` = idx3[7:4].
  - `cursor_start` = idx10[4:0] and `cursor_mode` = idx10[6:5].
  - The remaining fields are copied unchanged.
- R9: With `bus_cs` low, no register, index or flag changes from the bus. Reading the status byte does not clear any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0: index/status, 1: selected register |
| bus_cs | input | 1 | Access qualifier |
| bus_rnw | input | 1 | 1 read, 0 write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the presented access |
| pen_strobe | input | 1 | Light-pen capture strobe |
| update_strobe | input | 1 | Update event strobe |
| scan_addr | input | 14 | Current display memory address |
| vretrace | input | 1 | Scan is in vertical retrace |
| h_total | output | 8 | Index 0 |
| h_disp | output | 8 | Index 1 |
| hsync_pos | output | 8 | Index 2 |
| hsync_width | output | 4 | Index 3 bits 3:0 |
| vsync_width | output | 4 | Index 3 bits 7:4 |
| v_total | output | 7 | Index 4 |
| v_adjust | output | 5 | Index 5 |
| v_disp | output | 7 | Index 6 |
| vsync_pos | output | 7 | Index 7 |
| max_scan | output | 5 | Index 9 |
| cursor_start | output | 5 | Index 10 bits 4:0 |
| cursor_mode | output | 2 | Index 10 bits 6:5 |
| cursor_end | output | 5 | Index 11 |
| start_addr | output | 14 | Indices 12/13 |
| cursor_addr | output | 14 | Indices 14/15 |

## Verification
The register path is driven with all-ones writes to every width class. This separates correct per-index masking from a mask that is shared or shifted. Patterns such as 0xA5 and 0xC5 catch bit swaps and a dropped top bit.

Unimplemented and read-only indices get writes of nonzero data, followed by read-back through address 1. Each flag is tried three ways: set, set then cleared by the matching access, and set and cleared on the same edge. This tells the strobe-wins priority apart from clear-wins. Status reads are repeated, and accesses with `bus_cs` low are attempted, to show that neither has side effects. Index writes with the upper bits set confirm that only five bits select.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;
    localparam int DATA_W    = 8;
    localparam int IDX_W     = 5;
    localparam int MA_W      = 14;
    localparam int NUM_CTRL  = 16;
    localparam int PEN_HI    = 16;
    localparam int PEN_LO    = 17;
    localparam int UPD_IDX   = 31;
    localparam int ST_UPD    = 7;
    localparam int ST_PEN    = 6;
    localparam int ST_VRT    = 5;

    // implemented-bit mask of each writable control register
    function automatic logic [DATA_W-1:0] ctrl_mask(input int idx);
        case (idx)
            0, 1, 2, 3, 13, 15: ctrl_mask = 8'hFF;
            4, 6, 7, 10:        ctrl_mask = 8'h7F;
            5, 9, 11:           ctrl_mask = 8'h1F;
            12, 14:             ctrl_mask = 8'h3F;
            default:            ctrl_mask = 8'h00;
        endcase
    endfunction

    typedef struct packed {
        logic            upd_rdy;
        logic            pen_full;
        logic [MA_W-1:0] pen_addr;
    } flag_state_t;
endpackage

// File: rtl/vidctl_bus_decode.sv
module vidctl_bus_decode #(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_cs,
    input  logic              bus_rnw,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [IDX_W-1:0]  idx,
    output logic              reg_wr,
    output logic              reg_rd
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } dec_state_t;

    dec_state_t state_d, state_q;
    logic       idx_wr;

    always_comb begin
        idx_wr  = bus_cs && !bus_addr && !bus_rnw;
        reg_wr  = bus_cs && bus_addr && !bus_rnw;
        reg_rd  = bus_cs && bus_addr && bus_rnw;
        state_d = state_q;
        if (idx_wr) begin
            state_d.idx = bus_wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign idx = state_q.idx;

    // R1
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_addr && !bus_rnw) |=> (idx == $past(bus_wdata[IDX_W-1:0])));

    // R9
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && !bus_addr && !bus_rnw) |=> $stable(idx));
endmodule

// File: rtl/vidctl_ctrl_regs.sv
module vidctl_ctrl_regs
    import vidctl_pkg::*;
#(
    parameter int NUM = 16,
    parameter int IDX_W = 5,
    parameter int DW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       idx,
    input  logic [DW-1:0]          wdata,
    output logic [NUM-1:0][DW-1:0] regs
);
    genvar gi;
    generate
        for (gi = 0; gi < NUM; gi++) begin : g_reg
            localparam logic [DW-1:0] MASK = DW'(ctrl_mask(gi));
            logic [DW-1:0] val_d, val_q;

            always_comb begin
                val_d = val_q;
                if (wr_en && (idx == IDX_W'(gi))) begin
                    val_d = wdata & MASK;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else begin
                    val_q <= val_d;
                end
            end

            assign regs[gi] = val_q;
        end
    endgenerate

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));
endmodule

// File: rtl/vidctl_pen_status.sv
module vidctl_pen_status
    import vidctl_pkg::*;
#(
    parameter int MW = 14,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pen_strobe,
    input  logic             update_strobe,
    input  logic [MW-1:0]    scan_addr,
    input  logic [IDX_W-1:0] idx,
    input  logic             reg_wr,
    input  logic             reg_rd,
    output logic [MW-1:0]    pen_addr,
    output logic             pen_full,
    output logic             upd_rdy
);
    typedef struct packed {
        logic          upd_rdy;
        logic          pen_full;
        logic [MW-1:0] pen_addr;
    } st_t;

    st_t  st_d, st_q;
    logic pen_rd, upd_acc;

    always_comb begin
        pen_rd  = reg_rd && ((idx == IDX_W'(PEN_HI)) || (idx == IDX_W'(PEN_LO)));
        upd_acc = (reg_rd || reg_wr) && (idx == IDX_W'(UPD_IDX));
        st_d    = st_q;
        if (pen_rd) begin
            st_d.pen_full = 1'b0;
        end
        if (pen_strobe) begin
            st_d.pen_full = 1'b1;
            st_d.pen_addr = scan_addr;
        end
        if (upd_acc) begin
            st_d.upd_rdy = 1'b0;
        end
        if (update_strobe) begin
            st_d.upd_rdy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pen_addr = st_q.pen_addr;
    assign pen_full = st_q.pen_full;
    assign upd_rdy  = st_q.upd_rdy;

    // R5
    pen_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pen_strobe |=> (pen_full && (pen_addr == $past(scan_addr))));

    // R6
    pen_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pen_rd && !pen_strobe) |=> !pen_full);

    // R7
    upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_acc && !update_strobe) |=> !upd_rdy);

    // R9
    pen_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pen_strobe && !pen_rd) |=> ($stable(pen_full) && $stable(pen_addr)));
endmodule

// File: rtl/vidctl_regbank.sv
module vidctl_regbank
    import vidctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_cs,
    input  logic        bus_rnw,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        pen_strobe,
    input  logic        update_strobe,
    input  logic [13:0] scan_addr,
    input  logic        vretrace,
    output logic [7:0]  h_total,
    output logic [7:0]  h_disp,
    output logic [7:0]  hsync_pos,
    output logic [3:0]  hsync_width,
    output logic [3:0]  vsync_width,
    output logic [6:0]  v_total,
    output logic [4:0]  v_adjust,
    output logic [6:0]  v_disp,
    output logic [6:0]  vsync_pos,
    output logic [4:0]  max_scan,
    output logic [4:0]  cursor_start,
    output logic [1:0]  cursor_mode,
    output logic [4:0]  cursor_end,
    output logic [13:0] start_addr,
    output logic [13:0] cursor_addr
);
    localparam int HI_W = MA_W - DATA_W;

    logic [IDX_W-1:0]                 idx;
    logic                             reg_wr, reg_rd;
    logic [NUM_CTRL-1:0][DATA_W-1:0]  regs;
    logic [MA_W-1:0]                  pen_addr;
    logic                             pen_full, upd_rdy;

    vidctl_bus_decode #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dec_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs(bus_cs),
        .bus_rnw(bus_rnw), .bus_wdata(bus_wdata), .idx(idx),
        .reg_wr(reg_wr), .reg_rd(reg_rd)
    );

    vidctl_ctrl_regs #(.NUM(NUM_CTRL), .IDX_W(IDX_W), .DW(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .idx(idx),
        .wdata(bus_wdata), .regs(regs)
    );

    vidctl_pen_status #(.MW(MA_W), .IDX_W(IDX_W)) pen_i (
        .clk(clk), .rst_n(rst_n), .pen_strobe(pen_strobe),
        .update_strobe(update_strobe), .scan_addr(scan_addr), .idx(idx),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .pen_addr(pen_addr),
        .pen_full(pen_full), .upd_rdy(upd_rdy)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata[ST_UPD] = upd_rdy;
            bus_rdata[ST_PEN] = pen_full;
            bus_rdata[ST_VRT] = vretrace;
        end else if (idx < IDX_W'(NUM_CTRL)) begin
            bus_rdata = regs[idx[$clog2(NUM_CTRL)-1:0]];
        end else if (idx == IDX_W'(PEN_HI)) begin
            bus_rdata = DATA_W'(pen_addr[MA_W-1:DATA_W]);
        end else if (idx == IDX_W'(PEN_LO)) begin
            bus_rdata = pen_addr[DATA_W-1:0];
        end
    end

    assign h_total      = regs[0];
    assign h_disp       = regs[1];
    assign hsync_pos    = regs[2];
    assign hsync_width  = regs[3][3:0];
    assign vsync_width  = regs[3][7:4];
    assign v_total      = regs[4][6:0];
    assign v_adjust     = regs[5][4:0];
    assign v_disp       = regs[6][6:0];
    assign vsync_pos    = regs[7][6:0];
    assign max_scan     = regs[9][4:0];
    assign cursor_start = regs[10][4:0];
    assign cursor_mode  = regs[10][6:5];
    assign cursor_end   = regs[11][4:0];
    assign start_addr   = {regs[12][HI_W-1:0], regs[13]};
    assign cursor_addr  = {regs[14][HI_W-1:0], regs[15]};

    // R2
    status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_addr |-> ((bus_rdata[4:0] == 5'd0) && (bus_rdata[ST_VRT] == vretrace)));

    // R4
    unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr && ((idx == 5'd8) || (idx > 5'd17))) |-> (bus_rdata == 8'd0));
endmodule

// File: tb/vidctl_regbank_tb_top.sv
module vidctl_regbank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0, bus_cs = 1'b0, bus_rnw = 1'b1;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        pen_strobe = 1'b0, update_strobe = 1'b0, vretrace = 1'b0;
    logic [13:0] scan_addr = 14'd0;
    logic [7:0]  h_total, h_disp, hsync_pos;
    logic [3:0]  hsync_width, vsync_width;
    logic [6:0]  v_total, v_disp, vsync_pos;
    logic [4:0]  v_adjust, max_scan, cursor_start, cursor_end;
    logic [1:0]  cursor_mode;
    logic [13:0] start_addr, cursor_addr;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] rd;

    always #2.5 clk = ~clk;

    vidctl_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs(bus_cs),
        .bus_rnw(bus_rnw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pen_strobe(pen_strobe), .update_strobe(update_strobe),
        .scan_addr(scan_addr), .vretrace(vretrace), .h_total(h_total),
        .h_disp(h_disp), .hsync_pos(hsync_pos), .hsync_width(hsync_width),
        .vsync_width(vsync_width), .v_total(v_total), .v_adjust(v_adjust),
        .v_disp(v_disp), .vsync_pos(vsync_pos), .max_scan(max_scan),
        .cursor_start(cursor_start), .cursor_mode(cursor_mode),
        .cursor_end(cursor_end), .start_addr(start_addr),
        .cursor_addr(cursor_addr)
    );

    typedef struct packed {
        logic       a;
        logic       rnw;
        logic [7:0] d;
        logic [7:0] e;
    } vec_t;

    // R3 masking per width class, R4 unimplemented indices, R1 index hold
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'd0,  8'h00}, '{1'b1, 1'b0, 8'hA5, 8'h00}, '{1'b1, 1'b1, 8'h00, 8'hA5},
        '{1'b0, 1'b0, 8'd4,  8'h00}, '{1'b1, 1'b0, 8'hFF, 8'h00}, '{1'b1, 1'b1, 8'h00, 8'h7F},
        '{1'b0, 1'b0, 8'd5,  8'h00}, '{1'b1, 1'b0, 8'hFF, 8'h00}, '{1'b1, 1'b1, 8'h00, 8'h1F},
        '{1'b0, 1'b0, 8'd12, 8'h00}, '{1'b1, 1'b0, 8'hFF, 8'h00}, '{1'b1, 1'b1, 8'h00, 8'h3F},
        '{1'b0, 1'b0, 8'd8,  8'h00}, '{1'b1, 1'b0, 8'hFF, 8'h00}, '{1'b1, 1'b1, 8'h00, 8'h00},
        '{1'b0, 1'b0, 8'd20, 8'h00}, '{1'b1, 1'b0, 8'h55, 8'h00}, '{1'b1, 1'b1, 8'h00, 8'h00},
        '{1'b0, 1'b0, 8'd15, 8'h00}, '{1'b1, 1'b0, 8'h96, 8'h00}, '{1'b1, 1'b1, 8'h00, 8'h96},
        '{1'b0, 1'b0, 8'd0,  8'h00}, '{1'b1, 1'b1, 8'h00, 8'hA5}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic cs, input logic a, input logic rnw,
                          input logic [7:0] d, input logic pen, input logic upd,
                          output logic [7:0] r);
        @(negedge clk);
        bus_cs = cs; bus_addr = a; bus_rnw = rnw; bus_wdata = d;
        pen_strobe = pen; update_strobe = upd;
        #1 r = bus_rdata;
        @(posedge clk);
        #1;
        bus_cs = 1'b0; pen_strobe = 1'b0; update_strobe = 1'b0;
    endtask

    task automatic sel(input logic [7:0] i);
        logic [7:0] x;
        bus_op(1'b1, 1'b0, 1'b0, i, 1'b0, 1'b0, x);
    endtask

    task automatic wr(input logic [7:0] d);
        logic [7:0] x;
        bus_op(1'b1, 1'b1, 1'b0, d, 1'b0, 1'b0, x);
    endtask

    task automatic rdreg(output logic [7:0] r);
        bus_op(1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, r);
    endtask

    task automatic rdstat(output logic [7:0] r);
        bus_op(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0, r);
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 reset status, R1 reset index is 0
        rdstat(rd); check("R2 reset status", 16'(rd), 16'h00);
        rdreg(rd);  check("R1 reset index reads reg0", 16'(rd), 16'h00);
        check("R8 reset start_addr", 16'(start_addr), 16'h0000);

        for (int v = 0; v < NV; v++) begin
            bus_op(1'b1, VECS[v].a, VECS[v].rnw, VECS[v].d, 1'b0, 1'b0, rd);
            if (VECS[v].rnw) check($sformatf("R3/R4 vector %0d", v), 16'(rd), 16'(VECS[v].e));
        end
        check("R8 h_total", 16'(h_total), 16'h00A5);

        // R2 live retrace bit
        vretrace = 1'b1;
        rdstat(rd); check("R2 vretrace bit", 16'(rd), 16'h20);
        vretrace = 1'b0;

        // R5 capture, R9 status read has no side effect
        scan_addr = 14'h2ABC;
        bus_op(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, rd);
        rdstat(rd); check("R5 pen flag set", 16'(rd), 16'h40);
        rdstat(rd); check("R9 status read keeps flag", 16'(rd), 16'h40);
        sel(8'd16); rdreg(rd); check("R5 pen high", 16'(rd), 16'h2A);
        rdstat(rd); check("R6 read16 clears", 16'(rd), 16'h00);
        sel(8'd17); rdreg(rd); check("R5 pen low", 16'(rd), 16'hBC);
        sel(8'd16); wr(8'hFF); rdreg(rd); check("R4 read-only 16", 16'(rd), 16'h2A);

        // R6 strobe wins over clear on the same edge
        scan_addr = 14'h0155;
        sel(8'd17);
        bus_op(1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 1'b0, rd);
        check("R6 old value on same-edge read", 16'(rd), 16'hBC);
        rdstat(rd); check("R6 strobe wins", 16'(rd), 16'h40);
        rdreg(rd);  check("R5 new capture", 16'(rd), 16'h55);
        rdstat(rd); check("R6 read17 clears", 16'(rd), 16'h00);

        // R7 update flag
        bus_op(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, rd);
        rdstat(rd); check("R7 update set", 16'(rd), 16'h80);
        sel(8'd31); rdreg(rd); check("R4 index31 reads 0", 16'(rd), 16'h00);
        rdstat(rd); check("R7 read31 clears", 16'(rd), 16'h00);
        bus_op(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, rd);
        wr(8'h00);
        rdstat(rd); check("R7 write31 clears", 16'(rd), 16'h00);
        bus_op(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, rd);
        rdstat(rd); check("R7 strobe wins", 16'(rd), 16'h80);
        rdreg(rd);

        // R8 field outputs
        sel(8'd12); wr(8'h12); sel(8'd13); wr(8'h34);
        check("R8 start_addr", 16'(start_addr), 16'h1234);
        sel(8'd14); wr(8'hEF); sel(8'd15); wr(8'h01);
        check("R8 cursor_addr", 16'(cursor_addr), 16'h2F01);
        sel(8'd10); wr(8'hC5);
        check("R8 cursor_mode", 16'(cursor_mode), 16'h0002);
        check("R8 cursor_start", 16'(cursor_start), 16'h0005);
        rdreg(rd); check("R3 reg10 mask", 16'(rd), 16'h45);
        sel(8'd3); wr(8'h8B);
        check("R8 hsync_width", 16'(hsync_width), 16'h000B);
        check("R8 vsync_width", 16'(vsync_width), 16'h0008);

        // R9 no effect with chip select low
        bus_op(1'b0, 1'b1, 1'b0, 8'hEE, 1'b0, 1'b0, rd);
        bus_op(1'b0, 1'b0, 1'b0, 8'd7, 1'b0, 1'b0, rd);
        rdreg(rd); check("R9 cs low ignored", 16'(rd), 16'h8B);

        // R1 upper index bits ignored
        sel(8'd0); sel(8'hE3);
        rdreg(rd); check("R1 index low five bits", 16'(rd), 16'h8B);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule